// File: doc/BRIEF.md
# Wavetable Sample Memory with Playback Arbitration

This block holds the sixteen-byte sample table of a wavetable sound channel, where each byte packs two 4-bit samples. A processor reaches the table through a byte-wide read/write port. The playback engine supplies three inputs: whether the channel is running, whether the table is currently open to the processor, and the position of the sample being played. The block returns the current 4-bit sample to the playback engine on every clock.

While the channel is stopped, the processor port acts like a plain small memory. While the channel runs, the port is arbitrated against playback. If the open flag is set, a read returns the byte that playback is on, whatever offset was asked for, and a write still lands at the requested offset. If the flag is clear, reads return all ones and writes are discarded.

Read data and the sample output are both registered. Each appears one clock after the edge that sampled the request or the position.

Top module: `wave_sample_ram`

## Requirements
- R1: A synchronous active-high reset clears all sixteen bytes to 0x00 and sets `cpu_rdata` and `play_nibble` to zero.
- R2: Only bits [3:0] of `cpu_addr` select a byte. Bits [7:4] have no effect on which byte a read or write uses.
- R3: With `ch_playing` low, a read sampled at a clock edge returns, after that edge, the byte at the requested offset.
- R4: With `ch_playing` high and `ch_readable` high, a write is accepted and stored at the requested offset, not at the byte being played.
- R5: With `ch_playing` high and `ch_readable` low, a write is dropped and no byte of the table changes.
- R6: With `ch_playing` high and `ch_readable` high, a read returns the byte at index `play_pos[4:1]`, and the requested offset is ignored.
- R7: With `ch_playing` high and `ch_readable` low, a read returns 0xFF.
- R8: On every clock, `play_nibble` takes the byte at index `play_pos[4:1]`. It gives bits [7:4] of that byte when `play_pos[0]` is 0 and bits [3:0] when `play_pos[0]` is 1. This holds whether or not the channel is playing.
- R9: `cpu_rdata` holds its value on any clock where `cpu_rd_en` is low.
- R10: When a read and an accepted write fall on the same clock edge, the read returns the byte as it was before the write, and the playback sample also sees the old byte.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_rd_en | input | 1 | Processor read strobe |
| cpu_addr | input | 8 | Processor offset; only bits [3:0] are decoded |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Registered processor read data |
| ch_playing | input | 1 | Channel is running |
| ch_readable | input | 1 | Table is open to the processor during playback |
| play_pos | input | 5 | Current sample position (32 samples) |
| play_nibble | output | 4 | Registered sample at the current position |

## Verification
On every cycle, the assertions check four things: the all-ones read while the table is locked, that a locked write never reaches the storage, that read data is held between reads, and that an accepted write really changes the addressed byte. The cleared outputs after reset are also checked this way. Some behaviours show only in the bench's scenarios against its model. These are the redirection of reads to the played byte over a full position sweep, and the choice of high or low nibble. The bench scenarios also cover the ignored upper address bits, the read-before-write order on a shared edge, and the proof that a dropped write left the whole table untouched once the channel stops.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int unsigned WSR_DATA_W = 8;
  localparam int unsigned WSR_IDX_W  = 4;
  localparam int unsigned WSR_ADDR_W = 8;

  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_OPEN   = 2'd1,
    ACC_LOCKED = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/wsr_access_ctrl.sv
module wsr_access_ctrl
  import wsr_pkg::*;
#(
  parameter int unsigned ADDR_W = WSR_ADDR_W,
  parameter int unsigned IDX_W  = WSR_IDX_W,
  localparam int unsigned POS_W = IDX_W + 1
) (
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              ch_playing,
  input  logic              ch_readable,
  input  logic [POS_W-1:0]  play_pos,
  output acc_mode_e         mode,
  output logic              wr_go,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_blocked
);
  logic unused_addr_hi;
  logic [IDX_W-1:0] req_idx;

  generate
    if (ADDR_W > IDX_W) begin : g_hi
      assign unused_addr_hi = ^cpu_addr[ADDR_W-1:IDX_W];
    end else begin : g_nohi
      assign unused_addr_hi = 1'b0;
    end
  endgenerate

  assign req_idx = cpu_addr[IDX_W-1:0];

  always_comb begin
    if (!ch_playing)      mode = ACC_IDLE;
    else if (ch_readable) mode = ACC_OPEN;
    else                  mode = ACC_LOCKED;
  end

  always_comb begin
    wr_go      = 1'b0;
    rd_idx     = req_idx;
    rd_blocked = 1'b0;
    unique case (mode)
      ACC_IDLE: begin
        wr_go = cpu_wr_en;
      end
      ACC_OPEN: begin
        wr_go  = cpu_wr_en;
        rd_idx = play_pos[POS_W-1:1];
      end
      default: begin
        rd_blocked = 1'b1;
      end
    endcase
  end

  assign wr_idx = req_idx;
endmodule

// File: rtl/wsr_byte_store.sv
module wsr_byte_store
  import wsr_pkg::*;
#(
  parameter int unsigned DATA_W = WSR_DATA_W,
  parameter int unsigned IDX_W  = WSR_IDX_W,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        mem_q[i] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        mem_q[i] <= wr_data;
      end
    end
  end

  assign rd_a_data = mem_q[rd_a_idx];
  assign rd_b_data = mem_q[rd_b_idx];

  // R4
  store_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/wsr_nibble_pick.sv
module wsr_nibble_pick
  import wsr_pkg::*;
#(
  parameter int unsigned DATA_W = WSR_DATA_W,
  localparam int unsigned NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cur_byte,
  input  logic              low_half,
  output logic [NIB_W-1:0]  nibble
);
  always_ff @(posedge clk) begin
    if (rst)           nibble <= '0;
    else if (low_half) nibble <= cur_byte[NIB_W-1:0];
    else               nibble <= cur_byte[DATA_W-1:NIB_W];
  end
endmodule

// File: rtl/wave_sample_ram.sv
module wave_sample_ram
  import wsr_pkg::*;
#(
  parameter int unsigned DATA_W = WSR_DATA_W,
  parameter int unsigned ADDR_W = WSR_ADDR_W,
  parameter int unsigned IDX_W  = WSR_IDX_W,
  localparam int unsigned POS_W = IDX_W + 1,
  localparam int unsigned NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic              cpu_rd_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              ch_playing,
  input  logic              ch_readable,
  input  logic [POS_W-1:0]  play_pos,
  output logic [NIB_W-1:0]  play_nibble
);
  acc_mode_e         mode;
  logic              wr_go;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_blocked;
  logic [DATA_W-1:0] cpu_byte;
  logic [DATA_W-1:0] play_byte;

  wsr_access_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) ctrl_i (
    .cpu_wr_en  (cpu_wr_en),
    .cpu_addr   (cpu_addr),
    .ch_playing (ch_playing),
    .ch_readable(ch_readable),
    .play_pos   (play_pos),
    .mode       (mode),
    .wr_go      (wr_go),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .rd_blocked (rd_blocked)
  );

  wsr_byte_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_go),
    .wr_idx   (wr_idx),
    .wr_data  (cpu_wdata),
    .rd_a_idx (rd_idx),
    .rd_a_data(cpu_byte),
    .rd_b_idx (play_pos[POS_W-1:1]),
    .rd_b_data(play_byte)
  );

  wsr_nibble_pick #(.DATA_W(DATA_W)) nib_i (
    .clk     (clk),
    .rst     (rst),
    .cur_byte(play_byte),
    .low_half(play_pos[0]),
    .nibble  (play_nibble)
  );

  always_ff @(posedge clk) begin
    if (rst)            cpu_rdata <= '0;
    else if (cpu_rd_en) cpu_rdata <= rd_blocked ? '1 : cpu_byte;
  end

  // R1
  reset_clears_out_chk: assert property (@(posedge clk)
    rst |=> (cpu_rdata == '0 && play_nibble == '0));

  // R5
  locked_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr_en && ch_playing && !ch_readable) |-> !wr_go);

  // R7
  locked_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_en && ch_playing && !ch_readable) |=> (cpu_rdata == '1));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd_en |=> $stable(cpu_rdata));

  // R3
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !ch_playing |-> (mode == ACC_IDLE && !rd_blocked));
endmodule

// File: tb/wave_sample_ram_tb_top.sv
module wave_sample_ram_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr_en = 1'b0;
  logic       cpu_rd_en = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       ch_playing = 1'b0;
  logic       ch_readable = 1'b0;
  logic [4:0] play_pos = '0;
  logic [3:0] play_nibble;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] ref_mem [16];
  logic [7:0] ref_rdata;
  logic [3:0] ref_nib;

  always #4 clk = ~clk;

  wave_sample_ram dut_i (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ch_playing(ch_playing), .ch_readable(ch_readable),
    .play_pos(play_pos), .play_nibble(play_nibble)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, predict, compare at the following negedge.
  task automatic step(input string tag, input logic r, input logic we, input logic re,
                      input logic [7:0] a, input logic [7:0] wd,
                      input logic pl, input logic rd, input logic [4:0] pos);
    int widx;
    int pidx;
    rst = r; cpu_wr_en = we; cpu_rd_en = re; cpu_addr = a; cpu_wdata = wd;
    ch_playing = pl; ch_readable = rd; play_pos = pos;
    widx = int'(a % 16);
    pidx = int'(pos / 2);
    if (r) begin
      foreach (ref_mem[i]) ref_mem[i] = 8'h00;
      ref_rdata = 8'h00;
      ref_nib = 4'h0;
    end else begin
      ref_nib = (pos % 2 == 1) ? ref_mem[pidx][3:0] : ref_mem[pidx][7:4];
      if (re) begin
        if (!pl)     ref_rdata = ref_mem[widx];
        else if (rd) ref_rdata = ref_mem[pidx];
        else         ref_rdata = 8'hFF;
      end
      if (we && (!pl || rd)) ref_mem[widx] = wd;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, cpu_rdata, ref_rdata);
    check("R8 nibble", {4'h0, play_nibble}, {4'h0, ref_nib});
  endtask

  task automatic idle_read(input string tag, input logic [7:0] a);
    step(tag, 1'b0, 1'b0, 1'b1, a, 8'h00, 1'b0, 1'b0, 5'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int k = 0; k < 3; k++) step("R1 reset", 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 5'd0);
    for (int k = 0; k < 16; k++) idle_read("R1 cleared table", 8'(k));

    // R2: idle writes with junk in the upper address bits
    for (int k = 0; k < 16; k++)
      step("R2 idle write", 1'b0, 1'b1, 1'b0, 8'(8'hA0 + 8'(k)), 8'(k * 17 + 3), 1'b0, 1'b0, 5'(k));
    // R3 readback with different upper bits
    for (int k = 0; k < 16; k++) idle_read("R3 idle read", 8'(8'h50 | 8'(k)));
    // R9 hold with no read
    for (int k = 0; k < 4; k++) step("R9 hold", 1'b0, 1'b0, 1'b0, 8'(k), 8'h00, 1'b1, 1'b0, 5'(k));

    // R6 / R8: open-window reads sweep every position, offset fixed at 3
    for (int k = 0; k < 32; k++)
      step("R6 redirected read", 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 1'b1, 5'(k));

    // R4: accepted write during playback goes to offset 5, played byte is 10
    step("R4 open write", 1'b0, 1'b1, 1'b0, 8'h05, 8'hC7, 1'b1, 1'b1, 5'd20);
    idle_read("R4 offset byte", 8'h05);
    idle_read("R4 played byte untouched", 8'h0A);

    // R5 / R7: locked window
    for (int k = 0; k < 16; k++)
      step("R5 locked write", 1'b0, 1'b1, 1'b0, 8'(k), 8'h3C, 1'b1, 1'b0, 5'(2 * k));
    for (int k = 0; k < 4; k++)
      step("R7 locked read", 1'b0, 1'b0, 1'b1, 8'(k), 8'h00, 1'b1, 1'b0, 5'(k + 9));
    for (int k = 0; k < 16; k++) idle_read("R5 table unchanged", 8'(k));

    // R10: read and write on the same edge
    step("R10 idle rd+wr", 1'b0, 1'b1, 1'b1, 8'h07, 8'h99, 1'b0, 1'b0, 5'd14);
    step("R10 new value", 1'b0, 1'b0, 1'b1, 8'h07, 8'h00, 1'b0, 1'b0, 5'd14);
    step("R10 open rd+wr", 1'b0, 1'b1, 1'b1, 8'h07, 8'h5A, 1'b1, 1'b1, 5'd15);
    step("R10 open follow", 1'b0, 1'b0, 1'b1, 8'h07, 8'h00, 1'b1, 1'b1, 5'd15);

    // R1 again: reset mid-run clears contents
    step("R1 reset again", 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 5'd0);
    idle_read("R1 cleared after run", 8'h07);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule